// File: doc/BRIEF.md
# Pin Event Bank with Separate Assert and Deassert Interrupts

This block is a bank of up to 32 general-purpose pins controlled through a single-cycle register port. For each pin, software chooses whether the block drives it, what value it drives, whether its events can raise an interrupt, and which edge counts as the pin's "assert" edge. Each pad input passes through a two-flop synchronizer. The synchronized value is compared with its previous sample to find edges.

Every edge is sorted into one of two kinds. It is an assert event when the pin moves toward its programmed level, and a deassert event when it moves away from that level. Each kind is latched in its own sticky status words, which software clears by writing ones. Each kind also drives its own level-high interrupt line. That line is the OR of the latched events of that kind whose enable bit is set.

Status words hold 31 pins each. Bit 0 is never used, and the pin at position k inside the word is reported at bit k+1. Software is expected to clear both status bits of a pin before it enables that pin, so that stale events are thrown away.

Top module: `gpio_evt_bank`

## Requirements
- R1: After reset every register reads 0, every pin is an input (`pad_oe` all 0), `pad_out` is 0 and both interrupt lines are low.
- R2: The output enable register is at address 0, with a 1 meaning output. The output value register is at address 1. Bit n of each controls pin n directly on `pad_oe` and `pad_out`. The interrupt enable register is at address 3 and the polarity register is at address 4. All four read back what was written. Unmapped addresses read 0.
- R3: A read of address 2 returns, for each pin, the output value bit when the pin is an output. When the pin is an input, it returns the pad level after two-flop synchronization, which shows after the second rising clock edge.
- R4: A polarity bit of 1 makes a rising edge the pin's assert event and a falling edge its deassert event. A polarity bit of 0 swaps the two. An edge first shows in status after the third rising clock edge that follows the pad change.
- R5: Assert status word w is at address 5+2w and deassert status word w is at address 6+2w. Pin n is at word n/31, bit (n mod 31)+1. With 32 pins, pins 0..30 are at addresses 5 and 6, bits 1..31, and pin 31 is at bit 1 of addresses 7 and 8. Bit 0 of every status word reads 0, even after a 1 is written to it.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. Status bits latch events whether or not the pin's interrupt is enabled.
- R7: When a new event of a given kind and a clearing write to that bit take effect on the same clock edge, the bit ends up set.
- R8: `irq_assert` is high exactly while some pin has both its assert status and its enable bit set. `irq_deassert` behaves the same way for deassert status.
- R9: A write to the input data address (2) changes nothing. Later reads of all registers, and the pad outputs, are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Word address for read and write |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Driven pad values |
| pad_oe | output | 32 | Pad output enables |
| irq_assert | output | 1 | Pending enabled assert events |
| irq_deassert | output | 1 | Pending enabled deassert events |

## Verification
Two things can act on the same status bit in one cycle: an edge arriving from the synchronizer, and a software write of one to clear that bit. The bench finds this collision by counting the synchronizer and edge registers. It changes a pad and then places the clearing write so that it lands on the same edge that latches the new event. The pass condition is that the bit reads back as set afterwards. Separate cases check that a clearing write with no event present does empty the bit, and that writing zeros does not.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
    localparam int WORD_W       = 32;
    localparam int EVT_PER_WORD = WORD_W - 1;
    localparam int ADR_W        = 4;

    localparam int ADR_DIR       = 0;
    localparam int ADR_DOUT      = 1;
    localparam int ADR_DIN       = 2;
    localparam int ADR_IE        = 3;
    localparam int ADR_POL       = 4;
    localparam int ADR_STAT_BASE = 5;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t dir;
        word_t dout;
        word_t ie;
        word_t pol;
    } ctrl_t;
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;

    // R3: the second stage always carries the first stage one cycle later
    a_r3_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sync_o == $past(st_q.s1)));
endmodule

// File: rtl/gpb_edge.sv
module gpb_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] pol_i,
    output logic [W-1:0] assert_o,
    output logic [W-1:0] deassert_o
);
    logic [W-1:0] prev_d, prev_q;
    logic [W-1:0] rise, fall;

    always_comb begin
        prev_d     = sync_i;
        rise       = sync_i & ~prev_q;
        fall       = ~sync_i & prev_q;
        assert_o   = (pol_i & rise) | (~pol_i & fall);
        deassert_o = (pol_i & fall) | (~pol_i & rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // R4: a pin never reports both event kinds in one cycle
    a_r4_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (assert_o & deassert_o) == '0);
    // R4: comparison sample is the synchronized level of the previous cycle
    a_r4_prev_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prev_q == $past(sync_i)));
endmodule

// File: rtl/gpb_status.sv
module gpb_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] stat_d, stat_q;

    always_comb begin
        // clear first, then set, so a same-cycle event survives the clear
        stat_d = (stat_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q;

    // R7: every event lands in status on the next edge, clear or not
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i)));
    // R6: without a clearing write no latched bit is lost
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
    import gpb_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADR_W-1:0]  bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq_assert,
    output logic              irq_deassert
);
    localparam int    NWORDS   = (NPINS + EVT_PER_WORD - 1) / EVT_PER_WORD;
    localparam word_t PIN_MASK = word_t'((64'd1 << NPINS) - 64'd1);
    localparam int    STAT_END = ADR_STAT_BASE + 2 * NWORDS;

    ctrl_t ctrl_d, ctrl_q;

    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] ev_as, ev_ds;
    logic [NPINS-1:0] clr_as, clr_ds;
    logic [NPINS-1:0] st_as, st_ds;
    word_t            as_word [NWORDS];
    word_t            ds_word [NWORDS];
    word_t            din_word;

    gpb_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pad_in), .sync_o(pin_sync)
    );

    gpb_edge #(.W(NPINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .sync_i(pin_sync),
        .pol_i(ctrl_q.pol[NPINS-1:0]),
        .assert_o(ev_as), .deassert_o(ev_ds)
    );

    gpb_status #(.W(NPINS)) u_stat_as (
        .clk(clk), .rst_n(rst_n), .set_i(ev_as), .clr_i(clr_as), .stat_o(st_as)
    );

    gpb_status #(.W(NPINS)) u_stat_ds (
        .clk(clk), .rst_n(rst_n), .set_i(ev_ds), .clr_i(clr_ds), .stat_o(st_ds)
    );

    // control register writes
    always_comb begin
        ctrl_d = ctrl_q;
        if (bus_we) begin
            case (int'(bus_addr))
                ADR_DIR:  ctrl_d.dir  = bus_wdata & PIN_MASK;
                ADR_DOUT: ctrl_d.dout = bus_wdata & PIN_MASK;
                ADR_IE:   ctrl_d.ie   = bus_wdata & PIN_MASK;
                ADR_POL:  ctrl_d.pol  = bus_wdata & PIN_MASK;
                default:  ctrl_d = ctrl_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    // write-one-to-clear decode: pin p lives in word p/31 at bit p%31+1
    always_comb begin
        for (int p = 0; p < NPINS; p++) begin
            clr_as[p] = bus_we
                && (int'(bus_addr) == ADR_STAT_BASE + 2 * (p / EVT_PER_WORD))
                && bus_wdata[(p % EVT_PER_WORD) + 1];
            clr_ds[p] = bus_we
                && (int'(bus_addr) == ADR_STAT_BASE + 2 * (p / EVT_PER_WORD) + 1)
                && bus_wdata[(p % EVT_PER_WORD) + 1];
        end
    end

    // status words packed for readback, bit 0 held at zero
    generate
        for (genvar w = 0; w < NWORDS; w++) begin : g_word
            always_comb begin
                as_word[w] = '0;
                ds_word[w] = '0;
                for (int b = 1; b < WORD_W; b++) begin
                    if (w * EVT_PER_WORD + b - 1 < NPINS) begin
                        as_word[w][b] = st_as[w * EVT_PER_WORD + b - 1];
                        ds_word[w][b] = st_ds[w * EVT_PER_WORD + b - 1];
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        din_word = (ctrl_q.dir & ctrl_q.dout)
                 | (~ctrl_q.dir & PIN_MASK & word_t'(pin_sync));
    end

    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            ADR_DIR:  bus_rdata = ctrl_q.dir;
            ADR_DOUT: bus_rdata = ctrl_q.dout;
            ADR_DIN:  bus_rdata = din_word;
            ADR_IE:   bus_rdata = ctrl_q.ie;
            ADR_POL:  bus_rdata = ctrl_q.pol;
            default:  bus_rdata = '0;
        endcase
        for (int w = 0; w < NWORDS; w++) begin
            if (int'(bus_addr) == ADR_STAT_BASE + 2 * w)     bus_rdata = as_word[w];
            if (int'(bus_addr) == ADR_STAT_BASE + 2 * w + 1) bus_rdata = ds_word[w];
        end
    end

    assign pad_out      = ctrl_q.dout[NPINS-1:0];
    assign pad_oe       = ctrl_q.dir[NPINS-1:0];
    assign irq_assert   = |(st_as & ctrl_q.ie[NPINS-1:0]);
    assign irq_deassert = |(st_ds & ctrl_q.ie[NPINS-1:0]);

    // R5: status words never show anything in bit 0
    a_r5_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(bus_addr) >= ADR_STAT_BASE) && (int'(bus_addr) < STAT_END))
            |-> !bus_rdata[0]);
    // R8: with every enable clear, both lines stay quiet whatever is latched
    a_r8_quiet_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.ie == '0) |-> (!irq_assert && !irq_deassert));
endmodule

// File: tb/gpio_evt_bank_tb_top.sv
module gpio_evt_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq_assert, irq_deassert;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_evt_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_assert(irq_assert), .irq_deassert(irq_deassert)
    );

    // vector: {we, addr, wdata, expected read of addr afterwards}
    localparam int NV = 11;
    localparam logic [68:0] TBL [NV] = '{
        {1'b1, 4'd0, 32'hFFFF_0000, 32'hFFFF_0000},
        {1'b1, 4'd1, 32'h1234_5678, 32'h1234_5678},
        {1'b0, 4'd2, 32'h0,         32'h1234_0F0F},
        {1'b1, 4'd2, 32'hFFFF_FFFF, 32'h1234_0F0F},
        {1'b1, 4'd0, 32'h0000_FFFF, 32'h0000_FFFF},
        {1'b0, 4'd2, 32'h0,         32'hA5A5_5678},
        {1'b1, 4'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {1'b0, 4'd0, 32'h0,         32'h0000_FFFF},
        {1'b1, 4'd15, 32'hDEAD_BEEF, 32'h0},
        {1'b1, 4'd0, 32'h0,         32'h0},
        {1'b0, 4'd2, 32'h0,         32'hA5A5_0F0F}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        #3000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        idle(3);
        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), r);
            chk("R1 reset read", r, 32'h0);
        end
        chk("R1 pad_oe", pad_oe, 32'h0);
        chk("R1 pad_out", pad_out, 32'h0);
        chk("R1 irqs", {30'h0, irq_assert, irq_deassert}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        pad_in = 32'hA5A5_0F0F;
        idle(4);

        // table walk: R2 R3 R9
        for (int i = 0; i < NV; i++) begin
            if (TBL[i][68]) wr(TBL[i][67:64], TBL[i][63:32]);
            rd(TBL[i][67:64], r);
            chk($sformatf("R2 R3 R9 table entry %0d", i), r, TBL[i][31:0]);
            if (i == 4) begin
                chk("R2 pad_oe", pad_oe, 32'h0000_FFFF);
                chk("R2 pad_out", pad_out, 32'h1234_5678);
            end
            if (i == 3) begin
                rd(4'd0, r);
                chk("R9 dir untouched", r, 32'hFFFF_0000);
                rd(4'd1, r);
                chk("R9 dout untouched", r, 32'h1234_5678);
                chk("R9 pad_out untouched", pad_out, 32'h1234_5678);
            end
        end

        // quiet pads, clear all status
        pad_in = 32'h0;
        idle(4);
        for (int a = 5; a <= 8; a++) wr(4'(a), 32'hFFFF_FFFF);
        wr(4'd4, 32'hFFFF_FFDF);   // pin 5 polarity 0
        for (int a = 5; a <= 8; a++) begin
            rd(4'(a), r);
            chk("R6 cleared", r, 32'h0);
        end

        // R4 R5 pin 3 rising with polarity 1 -> assert bit 4
        @(negedge clk); pad_in[3] = 1'b1;
        idle(3);
        rd(4'd5, r); chk("R4 R5 pin3 rise assert", r, 32'h0000_0010);
        rd(4'd6, r); chk("R4 pin3 rise no deassert", r, 32'h0);
        chk("R8 masked irq", {30'h0, irq_assert, irq_deassert}, 32'h0);
        @(negedge clk); pad_in[3] = 1'b0;
        idle(3);
        rd(4'd6, r); chk("R4 pin3 fall deassert", r, 32'h0000_0010);
        // polarity 0 on pin 5
        @(negedge clk); pad_in[5] = 1'b1;
        idle(3);
        rd(4'd6, r); chk("R4 pin5 rise is deassert", r, 32'h0000_0050);
        rd(4'd5, r); chk("R4 pin5 rise no assert", r, 32'h0000_0010);
        @(negedge clk); pad_in[5] = 1'b0;
        idle(3);
        rd(4'd5, r); chk("R4 pin5 fall is assert", r, 32'h0000_0050);
        // R5 word boundary
        @(negedge clk); pad_in[31] = 1'b1; pad_in[30] = 1'b1;
        idle(3);
        rd(4'd7, r); chk("R5 pin31 high word", r, 32'h0000_0002);
        rd(4'd5, r); chk("R5 pin30 bit31", r, 32'h8000_0050);

        // R8 enable masking
        wr(4'd3, 32'h0000_0008);
        idle(1);
        chk("R8 pin3 enabled", {30'h0, irq_assert, irq_deassert}, 32'h3);
        wr(4'd3, 32'h8000_0000);
        idle(1);
        chk("R8 pin31 enabled", {30'h0, irq_assert, irq_deassert}, 32'h2);

        // R6 write-one-to-clear and write-zero
        wr(4'd5, 32'h0000_0010);
        rd(4'd5, r); chk("R6 w1c one bit", r, 32'h8000_0040);
        wr(4'd7, 32'h0);
        rd(4'd7, r); chk("R6 write zero keeps", r, 32'h0000_0002);
        wr(4'd5, 32'h0000_0001);
        rd(4'd5, r); chk("R5 bit0 stays zero", r, 32'h8000_0040);
        wr(4'd7, 32'h0000_0002);
        idle(1);
        chk("R8 irq drops after clear", {31'h0, irq_assert}, 32'h0);

        // R7 event and clear on the same edge
        @(negedge clk); pad_in[3] = 1'b1;
        idle(3);
        rd(4'd5, r); chk("R7 pre-set", r, 32'h8000_0050);
        @(negedge clk); pad_in[3] = 1'b0;
        idle(3);
        @(negedge clk); pad_in[3] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 4'd5; bus_wdata = 32'h0000_0010; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rd(4'd5, r); chk("R7 set wins over clear", r, 32'h8000_0050);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule